// File: doc/BRIEF.md
# Two-Port Configurable GPIO Bank

This block provides sixteen general-purpose pins split into two ports of eight. Software reaches it through a byte-wide configuration port: each access names a logical device number and an index inside that device. Logical device 0x07 holds, for every port, a direction byte, a data byte, an inversion byte and a read-only status byte. It also holds a port enable byte. Logical device 0x0F holds one output-mode byte per port, which selects open-drain or push-pull drive for each pin.

A write takes effect at the next rising clock edge. A read is combinational on the current logical device, index and state. The pad side gives a drive value and an output-enable for each pin. Pin levels come in through a two-flop synchronizer. The data byte returns the synchronized level for input pins and the latched value for output pins, with the inversion bit applied in both cases.

Top module: `gpb_bank`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` at the next rising edge. Direction, inversion and output-mode bytes read back as written. In logical device 0x07, port p's direction is at index 0xE0+4p, data at 0xE1+4p, inversion at 0xE2+4p and status at 0xE3+4p. In logical device 0x0F, port p's output mode is at index 0xE0+p.
- R2: After reset, both direction bytes read 0xFF. The data, inversion, output-mode and enable bytes read 0x00, and every `pin_oe` bit is low.
- R3: A direction bit of 1 makes the pin an input, and its `pin_oe` bit stays low. A direction bit of 0 makes the pin an output.
- R4: The effective output value of a pin is its data bit XOR its inversion bit. A push-pull output pin drives this value on `pin_out` with `pin_oe` high.
- R5: A read of a data byte returns, for each pin, the synchronized pin level when the pin is an input and the latched data bit when it is an output, XORed with that pin's inversion bit.
- R6: An output-mode bit of 1 selects open-drain. Such a pin has `pin_out` low, and its `pin_oe` is high only when its effective value is 0. An output-mode bit of 0 selects push-pull.
- R7: Index 0x30 in logical device 0x07 is the enable byte. Bit 0 enables port 0, bit 1 enables port 1, and bits 7:2 read 0. Every pin of a disabled port has `pin_oe` low.
- R8: A change on `pin_in` shows in the data byte read only after the second rising edge following the change.
- R9: Both status bytes read 0x00, and writes to them change nothing.
- R10: A write with any other logical device or index changes no register. The same index in different logical devices selects different registers, and unmapped locations read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ldev | input | 8 | Logical device number of the access |
| cfg_idx | input | 8 | Register index within the logical device |
| cfg_we | input | 1 | Write strobe, sampled at the rising edge |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Combinational read data for the addressed register |
| pin_in | input | 16 | Raw pad levels, pin n on bit n |
| pin_out | output | 16 | Pad drive values |
| pin_oe | output | 16 | Pad output-enables |

## Verification
The checker watches the pad rules on every cycle:
- no input pin is ever enabled;
- no open-drain pin drives high;
- a disabled port never enables a pad;
- status bytes always read zero;
- a direction write lands one edge later.

Only the bench scenarios can show the rest:
- the reset contents;
- how data, inversion and output mode combine into pad values;
- the exact two-edge synchronizer latency;
- the fact that writes to a foreign logical device or an unmapped index leave everything unchanged.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
    localparam int PORT_W    = 8;
    localparam int NUM_PORTS = 2;
    localparam int PIN_N     = PORT_W * NUM_PORTS;

    localparam logic [7:0] LDEV_IO       = 8'h07;
    localparam logic [7:0] LDEV_MODE     = 8'h0F;
    localparam logic [7:0] IDX_ENABLE    = 8'h30;
    localparam logic [7:0] IDX_IO_BASE   = 8'hE0;
    localparam logic [7:0] IDX_MODE_BASE = 8'hE0;

    // register slot inside one port's group of four
    typedef enum logic [1:0] {
        FLD_DIR  = 2'd0,
        FLD_DAT  = 2'd1,
        FLD_INV  = 2'd2,
        FLD_STAT = 2'd3
    } io_fld_e;

    typedef struct packed {
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] dat;
        logic [PORT_W-1:0] inv;
        logic [PORT_W-1:0] od;
    } port_regs_t;

    typedef struct packed {
        logic dir;
        logic dat;
        logic inv;
        logic od;
    } port_wr_t;

    function automatic logic [7:0] io_index(input int p, input io_fld_e f);
        return IDX_IO_BASE + 8'(4 * p) + 8'(f);
    endfunction

    function automatic logic [7:0] mode_index(input int p);
        return IDX_MODE_BASE + 8'(p);
    endfunction
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpb_port.sv
module gpb_port
    import gpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              port_en,
    input  port_wr_t          wr,
    input  logic [7:0]        wdata,
    input  logic [PORT_W-1:0] lvl_sync,
    output port_regs_t        regs,
    output logic [PORT_W-1:0] dat_rd,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe
);
    port_regs_t        regs_q;
    logic [PORT_W-1:0] eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.dir <= '1;
            regs_q.dat <= '0;
            regs_q.inv <= '0;
            regs_q.od  <= '0;
        end else begin
            if (wr.dir) regs_q.dir <= wdata[PORT_W-1:0];
            if (wr.dat) regs_q.dat <= wdata[PORT_W-1:0];
            if (wr.inv) regs_q.inv <= wdata[PORT_W-1:0];
            if (wr.od)  regs_q.od  <= wdata[PORT_W-1:0];
        end
    end

    assign regs   = regs_q;
    assign eff    = regs_q.dat ^ regs_q.inv;
    // input pins report the pad, output pins report the latch; inversion on both
    assign dat_rd = ((regs_q.dir & lvl_sync) | (~regs_q.dir & regs_q.dat)) ^ regs_q.inv;

    for (genvar i = 0; i < PORT_W; i++) begin : g_pad
        always_comb begin
            pad_out[i] = regs_q.od[i] ? 1'b0 : eff[i];
            pad_oe[i]  = port_en && !regs_q.dir[i] && (!regs_q.od[i] || !eff[i]);
        end
    end
endmodule

// File: rtl/gpb_bank.sv
module gpb_bank
    import gpb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       cfg_ldev,
    input  logic [7:0]       cfg_idx,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic [PIN_N-1:0] pin_in,
    output logic [PIN_N-1:0] pin_out,
    output logic [PIN_N-1:0] pin_oe
);
    logic [PIN_N-1:0]     lvl_sync;
    logic [NUM_PORTS-1:0] en_q;
    port_wr_t             wr_sel [NUM_PORTS];
    port_regs_t           regs   [NUM_PORTS];
    logic [PORT_W-1:0]    dat_rd [NUM_PORTS];
    logic [PIN_N-1:0]     dir_flat;
    logic [PIN_N-1:0]     od_flat;
    logic                 in_io;
    logic                 in_mode;

    assign in_io   = (cfg_ldev == LDEV_IO);
    assign in_mode = (cfg_ldev == LDEV_MODE);

    gpb_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (lvl_sync)
    );

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (cfg_we && in_io && cfg_idx == IDX_ENABLE)
            en_q <= cfg_wdata[NUM_PORTS-1:0];
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign wr_sel[p].dir = cfg_we && in_io   && cfg_idx == io_index(p, FLD_DIR);
        assign wr_sel[p].dat = cfg_we && in_io   && cfg_idx == io_index(p, FLD_DAT);
        assign wr_sel[p].inv = cfg_we && in_io   && cfg_idx == io_index(p, FLD_INV);
        assign wr_sel[p].od  = cfg_we && in_mode && cfg_idx == mode_index(p);

        gpb_port u_port (
            .clk      (clk),
            .rst      (rst),
            .port_en  (en_q[p]),
            .wr       (wr_sel[p]),
            .wdata    (cfg_wdata),
            .lvl_sync (lvl_sync[p*PORT_W +: PORT_W]),
            .regs     (regs[p]),
            .dat_rd   (dat_rd[p]),
            .pad_out  (pin_out[p*PORT_W +: PORT_W]),
            .pad_oe   (pin_oe[p*PORT_W +: PORT_W])
        );

        assign dir_flat[p*PORT_W +: PORT_W] = regs[p].dir;
        assign od_flat[p*PORT_W +: PORT_W]  = regs[p].od;
    end

    // status slots and unmapped indices fall through to zero
    always_comb begin
        cfg_rdata = '0;
        if (in_io) begin
            if (cfg_idx == IDX_ENABLE) cfg_rdata = 8'(en_q);
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (cfg_idx == io_index(p, FLD_DIR)) cfg_rdata = regs[p].dir;
                if (cfg_idx == io_index(p, FLD_DAT)) cfg_rdata = dat_rd[p];
                if (cfg_idx == io_index(p, FLD_INV)) cfg_rdata = regs[p].inv;
            end
        end else if (in_mode) begin
            for (int p = 0; p < NUM_PORTS; p++)
                if (cfg_idx == mode_index(p)) cfg_rdata = regs[p].od;
        end
    end
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker
    import gpb_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [7:0]           cfg_ldev,
    input logic [7:0]           cfg_idx,
    input logic                 cfg_we,
    input logic [7:0]           cfg_wdata,
    input logic [7:0]           cfg_rdata,
    input logic [PIN_N-1:0]     pin_out,
    input logic [PIN_N-1:0]     pin_oe,
    input logic [PIN_N-1:0]     dir_flat,
    input logic [PIN_N-1:0]     od_flat,
    input logic [NUM_PORTS-1:0] en_q
);
    a_r3_input_never_enabled: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & dir_flat) == '0);

    a_r6_open_drain_no_high: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & od_flat & pin_out) == '0);

    a_r9_status_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg_ldev == LDEV_IO && (cfg_idx == io_index(0, FLD_STAT) ||
                                 cfg_idx == io_index(1, FLD_STAT)))
        |-> cfg_rdata == 8'h00);

    a_r1_dir_write_lands: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_ldev == LDEV_IO && cfg_idx == io_index(0, FLD_DIR))
        |=> dir_flat[PORT_W-1:0] == $past(cfg_wdata));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_en
        a_r7_disabled_port_quiet: assert property (@(posedge clk) disable iff (rst)
            !en_q[p] |-> pin_oe[p*PORT_W +: PORT_W] == '0);
    end
endmodule

bind gpb_bank gpb_checker u_gpb_checker (
    .clk       (clk),
    .rst       (rst),
    .cfg_ldev  (cfg_ldev),
    .cfg_idx   (cfg_idx),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .dir_flat  (dir_flat),
    .od_flat   (od_flat),
    .en_q      (en_q)
);

// File: tb/test_gpb_bank.sv
`timescale 1ns/1ps
module test_gpb_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_ldev = 8'h00;
    logic [7:0]  cfg_idx = 8'h00;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [15:0] pin_in = 16'h0000;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpb_bank i_gpb_bank (
        .clk(clk), .rst(rst), .cfg_ldev(cfg_ldev), .cfg_idx(cfg_idx),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // {ldev, index, write value, expected read-back}
    localparam int NVEC = 10;
    localparam logic [31:0] VEC [NVEC] = '{
        32'h07_E0_A5_A5,  // R1 direction port 0
        32'h07_E4_3C_3C,  // R1 direction port 1
        32'h07_E2_0F_0F,  // R1 inversion port 0
        32'h07_E6_F0_F0,  // R1 inversion port 1
        32'h0F_E0_55_55,  // R1 mode port 0
        32'h0F_E1_AA_AA,  // R1 mode port 1
        32'h07_30_FF_03,  // R7 only two enable bits stored
        32'h07_E3_FF_00,  // R9 status port 0
        32'h07_E7_12_00,  // R9 status port 1
        32'h0F_E5_77_00   // R10 unmapped index
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] ld, input logic [7:0] ix, input logic [7:0] d);
        @(negedge clk);
        cfg_ldev = ld; cfg_idx = ix; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] ld, input logic [7:0] ix, output logic [7:0] d);
        cfg_ldev = ld; cfg_idx = ix;
        #0.5;
        d = cfg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        do_reset();

        // R2 reset state
        rd(8'h07, 8'hE0, r); check("R2 dir0", r, 8'hFF);
        rd(8'h07, 8'hE4, r); check("R2 dir1", r, 8'hFF);
        rd(8'h07, 8'hE2, r); check("R2 inv0", r, 8'h00);
        rd(8'h0F, 8'hE1, r); check("R2 mode1", r, 8'h00);
        rd(8'h07, 8'h30, r); check("R2 enable", r, 8'h00);
        rd(8'h07, 8'hE5, r); check("R2 data1", r, 8'h00);
        check("R2 oe", pin_oe, 16'h0000);

        for (int k = 0; k < NVEC; k++) begin
            wr(VEC[k][31:24], VEC[k][23:16], VEC[k][15:8]);
            rd(VEC[k][31:24], VEC[k][23:16], r);
            check("R1/R7/R9/R10 table", r, VEC[k][7:0]);
        end

        // R9 status writes left the other registers alone
        rd(8'h07, 8'hE0, r); check("R9 dir0 kept", r, 8'hA5);
        rd(8'h07, 8'hE4, r); check("R9 dir1 kept", r, 8'h3C);

        do_reset();
        rd(8'h07, 8'hE6, r); check("R2 inv1 after reset", r, 8'h00);

        // R4 push-pull outputs on port 0
        wr(8'h07, 8'h30, 8'h03);
        wr(8'h07, 8'hE0, 8'h00);
        wr(8'h07, 8'hE1, 8'h5A);
        @(negedge clk);
        check("R4 drive", pin_out[7:0], 8'h5A);
        check("R4 oe", pin_oe[7:0], 8'hFF);
        rd(8'h07, 8'hE1, r); check("R5 output read", r, 8'h5A);
        check("R3 inputs port1 oe", pin_oe[15:8], 8'h00);

        // R4 inversion
        wr(8'h07, 8'hE2, 8'h0F);
        @(negedge clk);
        check("R4 inverted drive", pin_out[7:0], 8'h55);
        rd(8'h07, 8'hE1, r); check("R5 inverted output read", r, 8'h55);

        // R6 open-drain on port 0
        wr(8'h0F, 8'hE0, 8'hFF);
        @(negedge clk);
        check("R6 od out", pin_out[7:0], 8'h00);
        check("R6 od oe", pin_oe[7:0], 8'hAA);

        // R3 mixed direction on port 0
        wr(8'h0F, 8'hE0, 8'h00);
        wr(8'h07, 8'hE0, 8'hF0);
        @(negedge clk);
        check("R3 mixed oe", pin_oe[7:0], 8'h0F);

        // R7 disable port 0
        wr(8'h07, 8'h30, 8'h02);
        @(negedge clk);
        check("R7 disabled oe", pin_oe[7:0], 8'h00);

        // R10 foreign logical device leaves direction alone
        wr(8'h08, 8'hE0, 8'h00);
        rd(8'h07, 8'hE0, r); check("R10 foreign ldev", r, 8'hF0);
        wr(8'h0F, 8'hE4, 8'h00);
        rd(8'h07, 8'hE4, r); check("R10 mode ldev E4", r, 8'hFF);

        // R8 synchronizer latency on port 1 inputs
        @(negedge clk);
        pin_in[15:8] = 8'hC3;
        @(negedge clk);
        rd(8'h07, 8'hE5, r); check("R8 one edge", r, 8'h00);
        @(negedge clk);
        rd(8'h07, 8'hE5, r); check("R8 two edges", r, 8'hC3);

        // R5 inverted input read
        wr(8'h07, 8'hE6, 8'hFF);
        rd(8'h07, 8'hE5, r); check("R5 inverted input", r, 8'h3C);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule